// File: doc/BRIEF.md
# Multi-Source PHY Reset Sequencer

This block builds the internal reset of a 10/100 Ethernet PHY out of three causes: a hardware reset (an on-chip power-on timer together with an active-low reset pin), a software reset requested by writing the reset bit of control register 0, and a reset raised while the device sits in power-down and for a settling time after it wakes. Each cause has its own stretch time, given in cycles of a free-running reference clock. The stretch times let the PLLs settle before the datapath is released.

The merged system reset is asserted asynchronously. Its release passes through a two-flop synchroniser, so it always ends on a clock edge. Two further outputs serve the management register bank. The hard output follows only the hardware reset and clears every register. The soft output follows hardware or software reset and clears the registers that are not marked as surviving a software reset. Power-down drives neither of them. A last output selects the slow (2.5 MHz) or fast (25 MHz) MII clock. It picks the fast clock only after a fixed time out of reset, and only if auto-negotiation is enabled.

Top module: `phy_rst_seq`

## Requirements
- R1: While `supply_ok` is low, `sys_rst`, `mgmt_rst_hard` and `mgmt_rst_soft` are high. After `supply_ok` rises they stay high through POR_CYCLES+1 clock edges and are low after edge POR_CYCLES+2.
- R2: A low level on `ext_rst_n` raises `sys_rst`, `mgmt_rst_hard` and `mgmt_rst_soft` at once, with no clock edge. After the pin returns high (power-on timer done), these outputs are still high after the first edge and low after the second. Every reset output is released only on a clock edge, through SYNC_STAGES flops.
- R3: A software reset starts on a clock edge where `ctl_wr_en` is high and `ctl_wr_b15` (bit 15 of the register 0 write data) is 1. A write with that bit at 0 leaves all outputs unchanged.
- R4: `sw_rst_bit` reads 1 from the write edge through SW_CYCLES edges, then clears itself on the next edge. `sys_rst` is high after the write edge and low after edge SW_CYCLES+3, counting the write edge as 1.
- R5: A software reset raises `mgmt_rst_soft` together with `sys_rst` and leaves `mgmt_rst_hard` low.
- R6: While `pd_en` is high, `sys_rst` is high. It is released PD_CYCLES+2 edges after the first edge that sees `pd_en` low. `mgmt_rst_hard` and `mgmt_rst_soft` stay low throughout.
- R7: A new software reset request during a running stretch reloads the full stretch, measured from the new request.
- R8: A hardware reset cancels a running software stretch at once: `sw_rst_bit` drops with no clock edge. After the hardware reset ends, `sys_rst` releases after SYNC_STAGES edges.
- R9: `mii_fast_sel` is 0 while `sys_rst` is high and for SLOW_CYCLES edges after `sys_rst` falls. On the next edge it becomes 1 if `aneg_en` is high. It stays 0 while `aneg_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| supply_ok | input | 1 | Supplies valid; low forces the power-on reset |
| ext_rst_n | input | 1 | External reset pin, active low |
| ctl_wr_en | input | 1 | Write strobe for control register 0 |
| ctl_wr_b15 | input | 1 | Bit 15 (reset request) of the register 0 write data |
| pd_en | input | 1 | Power-down mode active |
| aneg_en | input | 1 | Auto-negotiation enabled |
| sys_rst | output | 1 | Active-high system reset for PCS, DSP and MII logic |
| mgmt_rst_hard | output | 1 | Clears all management registers (hardware reset only) |
| mgmt_rst_soft | output | 1 | Clears management registers not kept across software reset |
| sw_rst_bit | output | 1 | Read-back of the self-clearing software reset bit |
| mii_fast_sel | output | 1 | 0 selects the 2.5 MHz MII clock, 1 selects 25 MHz |

## Verification
The bench targets the exact release edge of each source. A stretch counter that is off by one, or a synchroniser with the wrong number of stages, moves the fall of `sys_rst` by a cycle. A second software write in the middle of a stretch must push the release out. A design that ignores the reload lets the reset go early. A hardware pulse during a software stretch must cancel it. Without that, the reset lingers after the pin returns. The bench also checks that power-down and software reset leave the hard management reset alone, that a write with bit 15 clear does nothing, and that the fast MII clock waits for its delay and for auto-negotiation.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
  // Index of each synchronised reset output in the release vector
  localparam int unsigned IDX_SYS  = 0;
  localparam int unsigned IDX_HARD = 1;
  localparam int unsigned IDX_SOFT = 2;
  localparam int unsigned N_OUTS   = 3;
endpackage

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned CYCLES       = 16,
  parameter bit          LOAD_ON_ARST = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic req,
  output logic busy
);
  localparam int unsigned W = $clog2(CYCLES + 1);
  localparam logic [W-1:0] TOP = W'(CYCLES);
  localparam logic [W-1:0] ARST_VAL = LOAD_ON_ARST ? TOP : '0;

  logic [W-1:0] cnt;

  // Request (re)loads the full count; otherwise count down to zero
  always_ff @(posedge clk or posedge arst) begin
    if (arst)             cnt <= ARST_VAL;
    else if (req)         cnt <= TOP;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R7: a request always leaves the stretch running on the next cycle
  p_req_keeps_busy_r7: assert property (@(posedge clk) disable iff (arst)
    req |=> busy);

  // R4: a stretch can only end in a cycle with no request
  p_end_without_req_r4: assert property (@(posedge clk) disable iff (arst)
    $fell(busy) |-> !$past(req));
endmodule

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_in,
  output logic rst_out
);
  logic [STAGES-1:0] q;

  // Asynchronous assertion, release shifted through STAGES flops
  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in) q <= '1;
    else         q <= {q[STAGES-2:0], 1'b0};
  end

  assign rst_out = q[STAGES-1];

  // R2: release happens only after the source has been low for a full cycle
  p_release_after_src_r2: assert property (@(posedge clk) disable iff (arst_in)
    $fell(rst_out) |-> !$past(arst_in));
endmodule

// File: rtl/mii_speed_sel.sv
module mii_speed_sel #(
  parameter int unsigned SLOW_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic aneg_en,
  output logic fast_sel
);
  localparam int unsigned W = $clog2(SLOW_CYCLES + 1);
  localparam logic [W-1:0] LIMIT = W'(SLOW_CYCLES);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt      <= '0;
      fast_sel <= 1'b0;
    end else begin
      if (cnt != LIMIT) cnt <= cnt + 1'b1;
      fast_sel <= (cnt == LIMIT) && aneg_en;
    end
  end

  // R9: the fast clock is only chosen with auto-negotiation enabled
  p_fast_needs_aneg_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(fast_sel) |-> $past(aneg_en));
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
  import phy_rst_pkg::*;
#(
  parameter int unsigned POR_CYCLES  = 525000,
  parameter int unsigned SW_CYCLES   = 6400,
  parameter int unsigned PD_CYCLES   = 6400,
  parameter int unsigned SLOW_CYCLES = 400,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic ext_rst_n,
  input  logic ctl_wr_en,
  input  logic ctl_wr_b15,
  input  logic pd_en,
  input  logic aneg_en,
  output logic sys_rst,
  output logic mgmt_rst_hard,
  output logic mgmt_rst_soft,
  output logic sw_rst_bit,
  output logic mii_fast_sel
);
  logic por_busy, sw_busy, pd_busy;
  logic hw_src;
  logic [N_OUTS-1:0] raw_vec;
  logic [N_OUTS-1:0] rel_vec;

  // Power-on timer: held loaded while supplies are absent
  rst_stretch #(.CYCLES(POR_CYCLES), .LOAD_ON_ARST(1'b1)) u_por (
    .clk(clk), .arst(!supply_ok), .req(1'b0), .busy(por_busy)
  );

  assign hw_src = !ext_rst_n || por_busy;

  // Software reset stretch, cancelled by any hardware reset
  rst_stretch #(.CYCLES(SW_CYCLES), .LOAD_ON_ARST(1'b0)) u_sw (
    .clk(clk), .arst(hw_src), .req(ctl_wr_en && ctl_wr_b15), .busy(sw_busy)
  );

  // Power-down stretch: held during power-down, extended after exit
  rst_stretch #(.CYCLES(PD_CYCLES), .LOAD_ON_ARST(1'b0)) u_pd (
    .clk(clk), .arst(hw_src), .req(pd_en), .busy(pd_busy)
  );

  assign raw_vec[IDX_SYS]  = hw_src || sw_busy || pd_busy;
  assign raw_vec[IDX_HARD] = hw_src;
  assign raw_vec[IDX_SOFT] = hw_src || sw_busy;

  for (genvar i = 0; i < N_OUTS; i++) begin : g_sync
    rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_in(raw_vec[i]), .rst_out(rel_vec[i])
    );
  end

  assign sys_rst       = rel_vec[IDX_SYS];
  assign mgmt_rst_hard = rel_vec[IDX_HARD];
  assign mgmt_rst_soft = rel_vec[IDX_SOFT];
  assign sw_rst_bit    = sw_busy;

  mii_speed_sel #(.SLOW_CYCLES(SLOW_CYCLES)) u_mii (
    .clk(clk), .rst(sys_rst), .aneg_en(aneg_en), .fast_sel(mii_fast_sel)
  );

  // R4: a pending software reset always holds the system in reset
  p_sw_holds_sys_r4: assert property (@(posedge clk) disable iff (hw_src)
    sw_rst_bit |-> sys_rst);

  // R5: the soft register reset is never released before the hard one
  p_soft_covers_hard_r5: assert property (@(posedge clk) disable iff (hw_src)
    mgmt_rst_hard |-> mgmt_rst_soft);

  // R9: slow clock is forced while the system is in reset
  p_slow_in_reset_r9: assert property (@(posedge clk) disable iff (!supply_ok)
    sys_rst |-> !mii_fast_sel);

  // R6: power-down alone never touches the register bank resets
  p_pd_spares_regs_r6: assert property (@(posedge clk) disable iff (hw_src)
    (pd_busy && !sw_busy && !$past(sw_busy) && !$past(hw_src) && !$past(hw_src, 2))
      |-> !mgmt_rst_soft);
endmodule

// File: tb/sim_phy_rst_seq.sv
`timescale 1ns/1ps
module sim_phy_rst_seq;
  localparam int POR = 20;
  localparam int SW  = 12;
  localparam int PD  = 8;
  localparam int SLOW = 6;

  logic clk = 1'b0;
  logic supply_ok = 1'b0, ext_rst_n = 1'b1, ctl_wr_en = 1'b0, ctl_wr_b15 = 1'b0;
  logic pd_en = 1'b0, aneg_en = 1'b1;
  logic sys_rst, mgmt_rst_hard, mgmt_rst_soft, sw_rst_bit, mii_fast_sel;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phy_rst_seq #(.POR_CYCLES(POR), .SW_CYCLES(SW), .PD_CYCLES(PD),
                .SLOW_CYCLES(SLOW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .supply_ok(supply_ok), .ext_rst_n(ext_rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_b15(ctl_wr_b15), .pd_en(pd_en),
    .aneg_en(aneg_en), .sys_rst(sys_rst), .mgmt_rst_hard(mgmt_rst_hard),
    .mgmt_rst_soft(mgmt_rst_soft), .sw_rst_bit(sw_rst_bit),
    .mii_fast_sel(mii_fast_sel)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(input logic b15);
    ctl_wr_en = 1'b1; ctl_wr_b15 = b15;
    step(1);
    ctl_wr_en = 1'b0; ctl_wr_b15 = 1'b0;
  endtask

  task automatic t_por;
    step(3);
    chk("R1", "sys_rst no supply", sys_rst, 1'b1);
    chk("R1", "hard no supply", mgmt_rst_hard, 1'b1);
    chk("R1", "soft no supply", mgmt_rst_soft, 1'b1);
    chk("R9", "fast in reset", mii_fast_sel, 1'b0);
    chk("R4", "sw bit at reset", sw_rst_bit, 1'b0);
    supply_ok = 1'b1;
    step(POR + 1);
    chk("R1", "sys_rst before release", sys_rst, 1'b1);
    step(1);
    chk("R1", "sys_rst released", sys_rst, 1'b0);
    chk("R1", "hard released", mgmt_rst_hard, 1'b0);
    chk("R1", "soft released", mgmt_rst_soft, 1'b0);
  endtask

  task automatic t_mii_fast;
    step(SLOW);
    chk("R9", "still slow", mii_fast_sel, 1'b0);
    step(1);
    chk("R9", "fast after delay", mii_fast_sel, 1'b1);
  endtask

  task automatic t_sw;
    aneg_en = 1'b0;
    sw_write(1'b1);
    chk("R4", "sys_rst after write", sys_rst, 1'b1);
    chk("R5", "soft after write", mgmt_rst_soft, 1'b1);
    chk("R5", "hard stays low", mgmt_rst_hard, 1'b0);
    chk("R4", "bit set", sw_rst_bit, 1'b1);
    chk("R9", "slow on sw reset", mii_fast_sel, 1'b0);
    step(SW - 1);
    chk("R4", "bit still set", sw_rst_bit, 1'b1);
    step(1);
    chk("R4", "bit self-cleared", sw_rst_bit, 1'b0);
    step(1);
    chk("R4", "sys_rst one before", sys_rst, 1'b1);
    step(1);
    chk("R4", "sys_rst released", sys_rst, 1'b0);
    chk("R5", "soft released", mgmt_rst_soft, 1'b0);
    step(SLOW + 3);
    chk("R9", "no fast without aneg", mii_fast_sel, 1'b0);
    aneg_en = 1'b1;
  endtask

  task automatic t_sw_ignored;
    sw_write(1'b0);
    chk("R3", "bit15 clear no reset", sys_rst, 1'b0);
    chk("R3", "bit15 clear no bit", sw_rst_bit, 1'b0);
    step(2);
    chk("R3", "bit15 clear soft", mgmt_rst_soft, 1'b0);
  endtask

  task automatic t_restart;
    sw_write(1'b1);
    step(5);
    sw_write(1'b1);
    step(SW + 1);
    chk("R7", "restart holds reset", sys_rst, 1'b1);
    step(1);
    chk("R7", "restart release", sys_rst, 1'b0);
  endtask

  task automatic t_pd;
    pd_en = 1'b1;
    step(3);
    chk("R6", "sys_rst in pd", sys_rst, 1'b1);
    chk("R6", "soft untouched", mgmt_rst_soft, 1'b0);
    chk("R6", "hard untouched", mgmt_rst_hard, 1'b0);
    pd_en = 1'b0;
    step(PD + 1);
    chk("R6", "held after exit", sys_rst, 1'b1);
    chk("R6", "soft still low", mgmt_rst_soft, 1'b0);
    step(1);
    chk("R6", "released after exit", sys_rst, 1'b0);
  endtask

  task automatic t_pin;
    ext_rst_n = 1'b0;
    #1;
    chk("R2", "sys async", sys_rst, 1'b1);
    chk("R2", "hard async", mgmt_rst_hard, 1'b1);
    chk("R2", "soft async", mgmt_rst_soft, 1'b1);
    step(2);
    ext_rst_n = 1'b1;
    step(1);
    chk("R2", "sync stage 1", sys_rst, 1'b1);
    step(1);
    chk("R2", "sys released", sys_rst, 1'b0);
    chk("R2", "hard released", mgmt_rst_hard, 1'b0);
  endtask

  task automatic t_abort;
    sw_write(1'b1);
    step(3);
    chk("R8", "bit before abort", sw_rst_bit, 1'b1);
    ext_rst_n = 1'b0;
    #1;
    chk("R8", "bit cancelled", sw_rst_bit, 1'b0);
    step(1);
    ext_rst_n = 1'b1;
    step(2);
    chk("R8", "sys released after pin", sys_rst, 1'b0);
    chk("R8", "soft released after pin", mgmt_rst_soft, 1'b0);
  endtask

  initial begin
    t_por;
    t_mii_fast;
    t_sw;
    t_sw_ignored;
    t_restart;
    t_pd;
    t_pin;
    t_abort;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule